// File: doc/BRIEF.md
# Trimmed 1 Hz Prescaler with Oscillator Stall Monitor

This block turns a free-running 32,768 Hz oscillator into a one-second tick for a real-time clock. It also applies a signed digital trim so that a crystal that runs fast or slow can be corrected. All logic runs on a fast system clock. The oscillator input is treated as asynchronous: it passes through a synchroniser, and each of its rising edges becomes a one-cycle advance pulse for a binary divider.

The trim uses a long fixed interval of oscillator edges. At the end of each interval the calibration magnitude and direction are sampled. A correction is then applied over the edges that follow.
- Slowing the clock removes edges from the divider.
- Speeding it up makes edges count double.

The step for speeding up is twice the step for slowing down. A positive unit therefore moves the rate about twice as far as a negative unit. A tap of the same trimmed divider supplies a square wave for measuring the trim at a pin, gated by a test enable.

A separate monitor counts system-clock periods since the last synchronised oscillator edge. When that gap exceeds a limit worth about four oscillator periods, it sets a sticky fail flag. An enable turns the flag into an interrupt. All pins are plain control and status levels or pulses. No data stream crosses the boundary, so the block has no valid/ready handshake.

Top module: `rtc_trim_osc_mon`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `tick_1hz`, `ft_out`, `osc_fail` and `irq` are all 0.
- R2: With a calibration magnitude of 0, `tick_1hz` pulses once for every 2^DIV_BITS oscillator rising edges, whatever the direction bit.
- R3: The calibration inputs are sampled only on the oscillator edge that completes each run of TRIM_INTERVAL edges. The correction acts on the edges after that one.
- R4: With `cal_fast` = 0 and magnitude m, the divider ignores the next m*NEG_STEP oscillator edges.
- R5: With `cal_fast` = 1 and magnitude m, each of the next m*POS_STEP oscillator edges advances the divider by two instead of one.
- R6: Changing the calibration inputs while a correction is in progress has no effect on that correction.
- R7: `ft_out` is 0 whenever `ft_en` was 0 in the previous cycle. With `ft_en` = 1 it carries divider bit FT_LOG-1, a square wave with a period of 2^FT_LOG divider counts.
- R8: `osc_fail` becomes 1 once STALL_LIMIT system cycles pass with no synchronised oscillator rising edge. Shorter gaps never set it.
- R9: `osc_fail` stays 1 until `fail_clr` is pulsed while the oscillator is running. A clear that arrives during a stall is ignored.
- R10: `irq` is 1 exactly when `osc_fail` and `fail_ie` are both 1.
- R11: `tick_1hz` is never high for two consecutive system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Fast system clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_in | input | 1 | 32 kHz oscillator, asynchronous to sys_clk |
| cal_mag | input | CAL_W | Trim magnitude |
| cal_fast | input | 1 | Trim direction: 1 speeds up, 0 slows down |
| ft_en | input | 1 | Enables the frequency-test square wave |
| fail_ie | input | 1 | Enables the oscillator-fail interrupt |
| fail_clr | input | 1 | One-cycle request to clear the fail flag |
| tick_1hz | output | 1 | One-cycle pulse per divider wrap |
| ft_out | output | 1 | Frequency-test square wave |
| osc_fail | output | 1 | Sticky oscillator-stall flag |
| irq | output | 1 | Fail interrupt |

## Verification
The stall monitor's set condition and a software clear request can land in the same cycle. The bench provokes this by pulsing `fail_clr` while the oscillator is held still and the monitor keeps reporting a stall. It then checks that `osc_fail` stays 1, and that an identical pulse issued while edges are flowing does clear it. In the same way, a calibration change is made just after the interval edge has loaded a boost. Here the correction is in flight while new inputs arrive, and the bench judges the result by the tick count over the whole run, which must match the value that was sampled at the interval edge.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

  // Action applied to each oscillator edge while a correction is active.
  typedef enum logic [1:0] {
    CORR_NONE  = 2'd0,
    CORR_BLANK = 2'd1,
    CORR_BOOST = 2'd2
  } corr_mode_e;

  // Divider advance for a given correction mode.
  function automatic logic [1:0] advance_for(input corr_mode_e mode, input logic active);
    if (!active) return 2'd1;
    case (mode)
      CORR_BLANK: return 2'd0;
      CORR_BOOST: return 2'd2;
      default:    return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/rtc_osc_edge_sync.sv
module rtc_osc_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic sys_clk,
  input  logic rst_n,
  input  logic osc_in,
  output logic osc_rise
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  // Synchroniser chain, one flop per stage.
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge sys_clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= osc_in;
        end
      end else begin : g_next
        always_ff @(posedge sys_clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q   <= 1'b0;
      osc_rise <= 1'b0;
    end else begin
      last_q   <= sync_q[SYNC_STAGES-1];
      osc_rise <= sync_q[SYNC_STAGES-1] & ~last_q;
    end
  end

endmodule

// File: rtl/rtc_stall_monitor.sv
module rtc_stall_monitor #(
  parameter int STALL_LIMIT = 6104
) (
  input  logic sys_clk,
  input  logic rst_n,
  input  logic osc_rise,
  input  logic fail_clr,
  output logic fail_flag
);

  localparam int GAP_W = $clog2(STALL_LIMIT + 1);
  localparam logic [GAP_W-1:0] GAP_MAX  = GAP_W'(STALL_LIMIT);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(STALL_LIMIT - 1);

  logic [GAP_W-1:0] gap_q;
  logic             stalled_q;

  // Gap counter saturates at the limit; any edge restarts it.
  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q     <= '0;
      stalled_q <= 1'b0;
    end else if (osc_rise) begin
      gap_q     <= '0;
      stalled_q <= 1'b0;
    end else if (gap_q != GAP_MAX) begin
      gap_q <= gap_q + 1'b1;
      if (gap_q == GAP_LAST) stalled_q <= 1'b1;
    end
  end

  // Set wins over clear: a clear during a stall is dropped.
  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n)          fail_flag <= 1'b0;
    else if (stalled_q)  fail_flag <= 1'b1;
    else if (fail_clr)   fail_flag <= 1'b0;
  end

endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler
  import rtc_trim_pkg::*;
#(
  parameter int DIV_BITS      = 15,
  parameter int CAL_W         = 5,
  parameter int TRIM_INTERVAL = 125829120,
  parameter int NEG_STEP      = 128,
  parameter int POS_STEP      = 256,
  parameter int FT_LOG        = 6
) (
  input  logic             sys_clk,
  input  logic             rst_n,
  input  logic             osc_rise,
  input  logic [CAL_W-1:0] cal_mag,
  input  logic             cal_fast,
  output logic             tick,
  output logic             ft_wave
);

  localparam int IV_W     = (TRIM_INTERVAL > 1) ? $clog2(TRIM_INTERVAL) : 1;
  localparam int MAG_MAX  = (1 << CAL_W) - 1;
  localparam int STEP_MAX = (POS_STEP > NEG_STEP) ? POS_STEP : NEG_STEP;
  localparam int CORR_W   = $clog2(MAG_MAX * STEP_MAX + 1);
  localparam int SUM_W    = DIV_BITS + 1;
  localparam logic [IV_W-1:0] IV_LAST = IV_W'(TRIM_INTERVAL - 1);

  logic [IV_W-1:0]     iv_q;
  logic                iv_wrap;
  logic [CORR_W-1:0]   left_q;
  logic [CORR_W-1:0]   load_amt;
  corr_mode_e          mode_q;
  corr_mode_e          load_mode;
  logic [DIV_BITS-1:0] div_q;
  logic [SUM_W-1:0]    div_sum;
  logic [1:0]          adv;

  assign iv_wrap = (iv_q == IV_LAST);

  // Correction size snapshot, taken only on the interval edge.
  always_comb begin
    if (cal_mag == '0) begin
      load_mode = CORR_NONE;
      load_amt  = '0;
    end else if (cal_fast) begin
      load_mode = CORR_BOOST;
      load_amt  = CORR_W'(cal_mag) * CORR_W'(POS_STEP);
    end else begin
      load_mode = CORR_BLANK;
      load_amt  = CORR_W'(cal_mag) * CORR_W'(NEG_STEP);
    end
  end

  always_comb begin
    adv     = advance_for(mode_q, left_q != '0);
    div_sum = {1'b0, div_q} + SUM_W'(adv);
  end

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      iv_q   <= '0;
      left_q <= '0;
      mode_q <= CORR_NONE;
      div_q  <= '0;
      tick   <= 1'b0;
    end else if (osc_rise) begin
      div_q <= div_sum[DIV_BITS-1:0];
      tick  <= div_sum[DIV_BITS];
      if (iv_wrap) begin
        iv_q   <= '0;
        left_q <= load_amt;
        mode_q <= load_mode;
      end else begin
        iv_q <= iv_q + 1'b1;
        if (left_q != '0) left_q <= left_q - 1'b1;
      end
    end else begin
      tick <= 1'b0;
    end
  end

  assign ft_wave = div_q[FT_LOG-1];

endmodule

// File: rtl/rtc_trim_osc_mon.sv
module rtc_trim_osc_mon #(
  parameter int DIV_BITS      = 15,
  parameter int CAL_W         = 5,
  parameter int TRIM_INTERVAL = 125829120,
  parameter int NEG_STEP      = 128,
  parameter int POS_STEP      = 256,
  parameter int FT_LOG        = 6,
  parameter int STALL_LIMIT   = 6104,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             sys_clk,
  input  logic             rst_n,
  input  logic             osc_in,
  input  logic [CAL_W-1:0] cal_mag,
  input  logic             cal_fast,
  input  logic             ft_en,
  input  logic             fail_ie,
  input  logic             fail_clr,
  output logic             tick_1hz,
  output logic             ft_out,
  output logic             osc_fail,
  output logic             irq
);

  logic osc_rise;
  logic ft_wave;

  rtc_osc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .sys_clk (sys_clk),
    .rst_n   (rst_n),
    .osc_in  (osc_in),
    .osc_rise(osc_rise)
  );

  rtc_trim_prescaler #(
    .DIV_BITS     (DIV_BITS),
    .CAL_W        (CAL_W),
    .TRIM_INTERVAL(TRIM_INTERVAL),
    .NEG_STEP     (NEG_STEP),
    .POS_STEP     (POS_STEP),
    .FT_LOG       (FT_LOG)
  ) u_presc (
    .sys_clk (sys_clk),
    .rst_n   (rst_n),
    .osc_rise(osc_rise),
    .cal_mag (cal_mag),
    .cal_fast(cal_fast),
    .tick    (tick_1hz),
    .ft_wave (ft_wave)
  );

  rtc_stall_monitor #(.STALL_LIMIT(STALL_LIMIT)) u_mon (
    .sys_clk  (sys_clk),
    .rst_n    (rst_n),
    .osc_rise (osc_rise),
    .fail_clr (fail_clr),
    .fail_flag(osc_fail)
  );

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) ft_out <= 1'b0;
    else        ft_out <= ft_en & ft_wave;
  end

  assign irq = osc_fail & fail_ie;

endmodule

// File: rtl/rtc_trim_osc_mon_chk.sv
module rtc_trim_osc_mon_chk (
  input logic sys_clk,
  input logic rst_n,
  input logic ft_en,
  input logic fail_ie,
  input logic fail_clr,
  input logic tick_1hz,
  input logic ft_out,
  input logic osc_fail,
  input logic irq
);

  assert_irq_on_fail_R10: assert property (@(posedge sys_clk) disable iff (!rst_n)
    ($rose(osc_fail) && fail_ie) |-> irq);

  assert_irq_needs_flag_R10: assert property (@(posedge sys_clk) disable iff (!rst_n)
    irq |-> (osc_fail && fail_ie));

  assert_flag_sticky_R9: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (osc_fail && !fail_clr) |=> osc_fail);

  assert_flag_drop_cause_R9: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $fell(osc_fail) |-> $past(fail_clr));

  assert_ft_gated_R7: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !ft_en |=> !ft_out);

  assert_tick_single_R11: assert property (@(posedge sys_clk) disable iff (!rst_n)
    tick_1hz |=> !tick_1hz);

endmodule

bind rtc_trim_osc_mon rtc_trim_osc_mon_chk chk_i (
  .sys_clk (sys_clk),
  .rst_n   (rst_n),
  .ft_en   (ft_en),
  .fail_ie (fail_ie),
  .fail_clr(fail_clr),
  .tick_1hz(tick_1hz),
  .ft_out  (ft_out),
  .osc_fail(osc_fail),
  .irq     (irq)
);

// File: tb/rtc_trim_osc_mon_tb.sv
module rtc_trim_osc_mon_tb_top;

  localparam int DIV_BITS = 6;
  localparam int CAL_W    = 5;
  localparam int IVAL     = 256;
  localparam int NSTEP    = 2;
  localparam int PSTEP    = 4;
  localparam int FTL      = 4;
  localparam int STALL    = 32;
  localparam int HALF     = 4;

  logic sys_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic osc_in  = 1'b0;
  logic [CAL_W-1:0] cal_mag = '0;
  logic cal_fast = 1'b0;
  logic ft_en    = 1'b0;
  logic fail_ie  = 1'b0;
  logic fail_clr = 1'b0;
  logic tick_1hz, ft_out, osc_fail, irq;

  int checks = 0;
  int errors = 0;
  int tick_cnt = 0;
  int ft_rises = 0;
  int dbl_ticks = 0;
  logic tick_prev = 1'b0;
  logic ft_prev   = 1'b0;
  bit   done = 1'b0;

  always #10 sys_clk = ~sys_clk;

  rtc_trim_osc_mon #(
    .DIV_BITS(DIV_BITS), .CAL_W(CAL_W), .TRIM_INTERVAL(IVAL),
    .NEG_STEP(NSTEP), .POS_STEP(PSTEP), .FT_LOG(FTL),
    .STALL_LIMIT(STALL), .SYNC_STAGES(2)
  ) dut_i (
    .sys_clk(sys_clk), .rst_n(rst_n), .osc_in(osc_in),
    .cal_mag(cal_mag), .cal_fast(cal_fast), .ft_en(ft_en),
    .fail_ie(fail_ie), .fail_clr(fail_clr),
    .tick_1hz(tick_1hz), .ft_out(ft_out), .osc_fail(osc_fail), .irq(irq)
  );

  always @(negedge sys_clk) begin
    if (rst_n) begin
      if (tick_1hz) tick_cnt++;
      if (tick_1hz && tick_prev) dbl_ticks++;
      if (ft_out && !ft_prev) ft_rises++;
    end
    tick_prev = tick_1hz;
    ft_prev   = ft_out;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge sys_clk);
  endtask

  task automatic run_edges(input int n);
    for (int i = 0; i < n; i++) begin
      osc_in = 1'b1; idle(HALF);
      osc_in = 1'b0; idle(HALF);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; osc_in = 1'b0; fail_clr = 1'b0;
    idle(3);
    rst_n = 1'b1;
    tick_cnt = 0; ft_rises = 0;
  endtask

  function automatic int exp_ticks(input int edges, input int mag, input bit fast);
    int counts;
    counts = fast ? edges + mag * PSTEP : edges - mag * NSTEP;
    return counts / (1 << DIV_BITS);
  endfunction

  // R3 R4 R5: two full intervals, one correction applied after edge IVAL.
  task automatic trim_case(input int mag, input bit fast);
    int e;
    do_reset();
    cal_mag = CAL_W'(mag); cal_fast = fast;
    run_edges(2 * IVAL);
    idle(10);
    e = exp_ticks(2 * IVAL, mag, fast);
    if (mag == 0)
      check(tick_cnt == e, "R2 untrimmed tick rate", tick_cnt, e);
    else if (fast)
      check(tick_cnt == e, "R5 boost trim (R3 sampling)", tick_cnt, e);
    else
      check(tick_cnt == e, "R4 blank trim (R3 sampling)", tick_cnt, e);
  endtask

  initial begin
    void'($urandom(32'd20240611));

    // R1 reset values
    rst_n = 1'b0; fail_ie = 1'b1; ft_en = 1'b1;
    idle(3);
    check(!tick_1hz && !ft_out && !osc_fail && !irq, "R1 reset outputs", {tick_1hz, ft_out, osc_fail, irq}, 0);
    rst_n = 1'b1;
    idle(1);
    check(!tick_1hz && !ft_out && !osc_fail && !irq, "R1 after release", {tick_1hz, ft_out, osc_fail, irq}, 0);
    ft_en = 1'b0; fail_ie = 1'b0;

    // Directed trim corners
    trim_case(0, 1'b0);
    trim_case(0, 1'b1);
    trim_case(31, 1'b1);
    trim_case(31, 1'b0);
    trim_case(1, 1'b0);
    for (int k = 0; k < 6; k++) trim_case(int'($urandom_range(31, 0)), 1'($urandom_range(1, 0)));

    // R6: inputs change mid-correction; expected follows sampled value
    do_reset();
    cal_mag = 5'd31; cal_fast = 1'b1;
    run_edges(IVAL + 4);
    cal_mag = 5'd31; cal_fast = 1'b0;
    run_edges(IVAL - 4);
    idle(10);
    check(tick_cnt == exp_ticks(2 * IVAL, 31, 1'b1), "R6 change ignored in flight", tick_cnt, exp_ticks(2 * IVAL, 31, 1'b1));

    // R7 frequency test
    cal_mag = '0; ft_en = 1'b0;
    do_reset();
    run_edges(2 * IVAL); idle(10);
    check(ft_rises == 0, "R7 ft off", ft_rises, 0);
    ft_en = 1'b1;
    do_reset();
    run_edges(2 * IVAL); idle(10);
    check(ft_rises == (2 * IVAL) / (1 << FTL), "R7 ft square rate", ft_rises, (2 * IVAL) / (1 << FTL));
    ft_en = 1'b0;

    // R8 short gap then long stall
    fail_ie = 1'b0;
    do_reset();
    run_edges(20);
    idle(3 * 2 * HALF);
    check(osc_fail == 1'b0, "R8 short gap no flag", osc_fail, 0);
    run_edges(4);
    idle(STALL + 20);
    check(osc_fail == 1'b1, "R8 stall sets flag", osc_fail, 1);
    check(irq == 1'b0, "R10 irq masked", irq, 0);
    fail_ie = 1'b1; idle(1);
    check(irq == 1'b1, "R10 irq enabled", irq, 1);

    // R9 clear during stall collides with set
    fail_clr = 1'b1; idle(1); fail_clr = 1'b0; idle(2);
    check(osc_fail == 1'b1, "R9 clear ignored while stalled", osc_fail, 1);
    run_edges(4);
    check(osc_fail == 1'b1, "R9 sticky while running", osc_fail, 1);
    fork
      run_edges(8);
      begin idle(20); fail_clr = 1'b1; idle(1); fail_clr = 1'b0; end
    join
    idle(2);
    check(osc_fail == 1'b0, "R9 clear while running", osc_fail, 0);
    check(irq == 1'b0, "R10 irq follows flag", irq, 0);

    check(dbl_ticks == 0, "R11 tick single cycle", dbl_ticks, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge sys_clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule